// File: doc/BRIEF.md
# Three-Wire Configuration Port with Status Readback

This block is the slave side of a three-wire serial configuration port. A host drives a serial clock, a data line and a latch strobe. The block collects each 32-bit frame in a shift register and, when the strobe rises, copies the frame into one of sixteen configuration registers. The target register is chosen by the frame's low address bits. The full register contents are presented in parallel to the rest of the chip.

Writing a frame to the readback-control register with its enable bit set starts a status readback. The host then keeps the strobe high and supplies eighteen serial clocks. A mode field in that frame picks a 16-bit status word, built from parallel inputs: signal level with gain settings, frequency offset, a voltage or temperature measurement, silicon revision, or a calibration result. The word is driven out MSB first on a data output with a separate output-enable, and the enable goes to the pad's tristate control. The first driven bit is a dummy, and the eighteenth clock releases the pad.

All serial inputs are resynchronised into the system clock domain, and edges are detected there. The chip-enable input gates the whole port.

Top module: `tw_cfg_port`

## Requirements
- R1: While chip-enable is high and the strobe is low, every rising serial clock edge shifts the data line into the 32-bit shift register at bit 0, moving older bits toward bit 31, so the first bit sent ends up in bit 31.
- R2: A rising strobe edge with chip-enable high copies the shift register into register N, where N is bits 3..0 of the frame. No other register changes.
- R3: After reset all sixteen registers read zero and the readback output is released (enable low, data low).
- R4: A readback starts only when the latched frame targets register 7 and has bit 8 set. Bits 6..4 select the word: 0 signal level, 1 frequency offset, 2 measurement, 3 revision, 4 calibration. Values 5 to 7 give an all-zero word.
- R5: Once a readback has started, the first rising serial clock edge enables the output with a dummy bit. Edges 2 to 17 place word bits 15 down to 0. Edge 18 releases the output, and later edges leave it released.
- R6: The signal-level word is LNA gain in bits 10..9, filter gain in bits 8..7 and the 7-bit level in bits 6..0, with bits 15..11 zero. The measurement word uses bits 6..0, the calibration word uses bits 7..0, and all of their other bits are zero.
- R7: A falling strobe during a readback aborts it and releases the output at once.
- R8: While chip-enable is low, clocks and strobes are ignored (no shift, no latch, no readback start), and any readback in progress is aborted.
- R9: A frame to register 7 with bit 8 clear is stored but does not enable the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Port enable |
| sclk_i | input | 1 | Serial clock |
| sdata_i | input | 1 | Serial data in |
| sle_i | input | 1 | Latch strobe |
| lna_gain_i | input | 2 | LNA gain code for signal-level word |
| filt_gain_i | input | 2 | Filter gain code for signal-level word |
| level_i | input | 7 | Signal level value |
| freq_ofs_i | input | 16 | Signed frequency offset |
| meas_i | input | 7 | Voltage or temperature measurement |
| rev_i | input | 16 | Silicon revision word |
| cal_i | input | 8 | Filter calibration result |
| regs_o | output | 512 | Register N at bits N*32+31..N*32 |
| sread_o | output | 1 | Readback data |
| sread_en_o | output | 1 | Readback output enable for the pad |

## Verification
A wrong shift or address decode shows up on the parallel register outputs a few system clocks after the strobe edge. It appears as a frame in the wrong slot, a bit-reversed value or a neighbour overwritten. A wrong readback counter or mux shows at the readback pins on the first serial clock. From there the enable rises one edge late or early, or the 16-bit word arrives shifted or from the wrong source, and a missing release shows as the enable still high after the eighteenth edge or after the strobe falls. Every register slot, every mode and every gain code combination is swept, so a fault in a single slot or field is seen in the first pass that reaches it.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int RB_W     = 16;
  localparam int LEVEL_W  = 7;
  localparam int GAIN_W   = 2;
  localparam int CAL_W    = 8;
  localparam int MODE_W   = 3;

  typedef enum logic [MODE_W-1:0] {
    RB_LEVEL  = 3'd0,
    RB_OFFSET = 3'd1,
    RB_MEAS   = 3'd2,
    RB_REV    = 3'd3,
    RB_CAL    = 3'd4
  } rb_mode_e;

  typedef enum logic [1:0] {
    RB_IDLE   = 2'd0,
    RB_ACTIVE = 2'd1,
    RB_DONE   = 2'd2
  } rb_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = stg_q[STAGES-1] & ~prev_q;
  assign fall_o = ~stg_q[STAGES-1] & prev_q;
endmodule

// File: rtl/tw_shift.sv
module tw_shift #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         din_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sr_q <= '0;
    else if (en_i) sr_q <= {sr_q[W-2:0], din_i};
  end

  assign word_o = sr_q;
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [REG_W-1:0]          data_i,
  output logic [NUM_REGS*REG_W-1:0] regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [REG_W-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               r_q <= '0;
      else if (wr_i && addr_i == ADDR_W'(g))     r_q <= data_i;
    end
    assign regs_o[g*REG_W +: REG_W] = r_q;
  end
endmodule

// File: rtl/tw_readback.sv
module tw_readback
  import tw_pkg::*;
#(
  localparam int CNT_W = $clog2(RB_W + 3)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [MODE_W-1:0]   mode_i,
  input  logic                step_i,
  input  logic                abort_i,
  input  logic [GAIN_W-1:0]   lna_gain_i,
  input  logic [GAIN_W-1:0]   filt_gain_i,
  input  logic [LEVEL_W-1:0]  level_i,
  input  logic [RB_W-1:0]     freq_ofs_i,
  input  logic [LEVEL_W-1:0]  meas_i,
  input  logic [RB_W-1:0]     rev_i,
  input  logic [CAL_W-1:0]    cal_i,
  output logic                sread_o,
  output logic                sread_en_o
);
  rb_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RB_W-1:0]  word_q;
  logic [RB_W-1:0]  word_sel;
  logic             out_q, en_q;

  always_comb begin
    word_sel = '0;
    case (mode_i)
      RB_LEVEL:  word_sel = RB_W'({lna_gain_i, filt_gain_i, level_i});
      RB_OFFSET: word_sel = freq_ofs_i;
      RB_MEAS:   word_sel = RB_W'(meas_i);
      RB_REV:    word_sel = rev_i;
      RB_CAL:    word_sel = RB_W'(cal_i);
      default:   word_sel = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RB_IDLE;
      cnt_q   <= '0;
      word_q  <= '0;
      out_q   <= 1'b0;
      en_q    <= 1'b0;
    end else if (abort_i) begin
      state_q <= RB_IDLE;
      out_q   <= 1'b0;
      en_q    <= 1'b0;
    end else if (start_i) begin
      state_q <= RB_ACTIVE;
      cnt_q   <= '0;
      word_q  <= word_sel;
      out_q   <= 1'b0;
      en_q    <= 1'b0;
    end else if (state_q == RB_ACTIVE && step_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) begin
        en_q  <= 1'b1;            // dummy bit
        out_q <= 1'b0;
      end else if (cnt_q <= CNT_W'(RB_W)) begin
        out_q  <= word_q[RB_W-1];
        word_q <= {word_q[RB_W-2:0], 1'b0};
      end else begin
        en_q    <= 1'b0;          // release clock
        out_q   <= 1'b0;
        state_q <= RB_DONE;
      end
    end
  end

  assign sread_o    = out_q;
  assign sread_en_o = en_q;
endmodule

// File: rtl/tw_cfg_port.sv
module tw_cfg_port
  import tw_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int REG_W       = 32,
  parameter int RB_REG      = 7,
  parameter int RB_EN_BIT   = 8,
  parameter int MODE_LSB    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(NUM_REGS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ce_i,
  input  logic                      sclk_i,
  input  logic                      sdata_i,
  input  logic                      sle_i,
  input  logic [GAIN_W-1:0]         lna_gain_i,
  input  logic [GAIN_W-1:0]         filt_gain_i,
  input  logic [LEVEL_W-1:0]        level_i,
  input  logic [RB_W-1:0]           freq_ofs_i,
  input  logic [LEVEL_W-1:0]        meas_i,
  input  logic [RB_W-1:0]           rev_i,
  input  logic [CAL_W-1:0]          cal_i,
  output logic [NUM_REGS*REG_W-1:0] regs_o,
  output logic                      sread_o,
  output logic                      sread_en_o
);
  localparam int I_SCLK = 0;
  localparam int I_SDAT = 1;
  localparam int I_SLE  = 2;
  localparam int I_CE   = 3;

  logic [3:0] s_lvl, s_rise, s_fall;
  logic [REG_W-1:0] frame;
  logic sclk_rise, sle_lvl, ce_lvl, latch_ev, shift_en, rb_start, rb_abort;

  tw_sync #(.W(4), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni,
    .d_i   ({ce_i, sle_i, sdata_i, sclk_i}),
    .lvl_o (s_lvl),
    .rise_o(s_rise),
    .fall_o(s_fall)
  );

  assign sclk_rise = s_rise[I_SCLK];
  assign sle_lvl   = s_lvl[I_SLE];
  assign ce_lvl    = s_lvl[I_CE];
  assign shift_en  = sclk_rise & ce_lvl & ~sle_lvl;
  assign latch_ev  = s_rise[I_SLE] & ce_lvl;
  assign rb_start  = latch_ev && frame[ADDR_W-1:0] == ADDR_W'(RB_REG) && frame[RB_EN_BIT];
  assign rb_abort  = s_fall[I_SLE] | ~ce_lvl;

  tw_shift #(.W(REG_W)) i_shift (
    .clk_i, .rst_ni,
    .en_i  (shift_en),
    .din_i (s_lvl[I_SDAT]),
    .word_o(frame)
  );

  tw_regfile #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) i_regs (
    .clk_i, .rst_ni,
    .wr_i  (latch_ev),
    .addr_i(frame[ADDR_W-1:0]),
    .data_i(frame),
    .regs_o(regs_o)
  );

  tw_readback i_rb (
    .clk_i, .rst_ni,
    .start_i    (rb_start),
    .mode_i     (frame[MODE_LSB +: MODE_W]),
    .step_i     (sclk_rise & ce_lvl & sle_lvl),
    .abort_i    (rb_abort),
    .lna_gain_i, .filt_gain_i, .level_i, .freq_ofs_i, .meas_i, .rev_i, .cal_i,
    .sread_o, .sread_en_o
  );
endmodule

// File: rtl/tw_cfg_port_chk.sv
module tw_cfg_port_chk #(
  parameter int NUM_REGS = 16,
  parameter int REG_W    = 32
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      sle_lvl,
  input logic                      ce_lvl,
  input logic                      sclk_rise,
  input logic                      latch_ev,
  input logic [NUM_REGS*REG_W-1:0] regs_o,
  input logic                      sread_o,
  input logic                      sread_en_o
);
  // R2: registers move only on a latch event
  p_regs_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_ev |=> $stable(regs_o));
  // R7: strobe low releases the output on the next cycle
  p_abort_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sle_lvl |=> !sread_en_o);
  // R8: disabled port never drives
  p_ce_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_lvl |=> !sread_en_o);
  // R5: enable only rises on a serial clock edge
  p_en_on_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sread_en_o) |-> $past(sclk_rise));
  // R3: released pin carries no data
  p_quiet_when_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sread_en_o |-> !sread_o);
endmodule

bind tw_cfg_port tw_cfg_port_chk #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) i_chk (
  .clk_i, .rst_ni,
  .sle_lvl(sle_lvl), .ce_lvl(ce_lvl), .sclk_rise(sclk_rise), .latch_ev(latch_ev),
  .regs_o, .sread_o, .sread_en_o
);

// File: tb/test_tw_cfg_port.sv
module test_tw_cfg_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b1, sclk = 1'b0, sdata = 1'b0, sle = 1'b0;
  logic [1:0] lna = '0, filt = '0;
  logic [6:0] level = '0, meas = '0;
  logic [15:0] fofs = '0, rev = '0;
  logic [7:0] cal = '0;
  logic [511:0] regs;
  logic sread, sread_en;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [31:0] shadow [16];

  always #5 clk = ~clk;

  tw_cfg_port i_tw_cfg_port (
    .clk_i(clk), .rst_ni(rst_n), .ce_i(ce), .sclk_i(sclk), .sdata_i(sdata), .sle_i(sle),
    .lna_gain_i(lna), .filt_gain_i(filt), .level_i(level), .freq_ofs_i(fofs),
    .meas_i(meas), .rev_i(rev), .cal_i(cal),
    .regs_o(regs), .sread_o(sread), .sread_en_o(sread_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1; wait_clk(4);
    sclk = 1'b0; wait_clk(4);
  endtask

  task automatic shift_word(input logic [31:0] w);
    for (int b = 31; b >= 0; b--) begin
      sdata = w[b];
      pulse();
    end
  endtask

  task automatic write_reg(input logic [31:0] w);
    shift_word(w);
    sle = 1'b1; wait_clk(8);
    sle = 1'b0; wait_clk(8);
    if (ce) shadow[w[3:0]] = w;
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 16; i++) chk(req, regs[i*32 +: 32], shadow[i]);
  endtask

  // R4 R5: full 18-clock readback and one extra clock
  task automatic readback(input logic [2:0] mode, input logic [15:0] exp, input string req);
    logic [31:0] w;
    w = {23'd0, 1'b1, 1'b0, mode, 4'd7};
    shift_word(w);
    sle = 1'b1; wait_clk(8);
    shadow[7] = w;
    chk("R4 ctl stored", regs[7*32 +: 32], w);
    chk("R5 off before edge1", {31'd0, sread_en}, 32'd0);
    for (int k = 1; k <= 19; k++) begin
      pulse();
      if (k == 1)       chk("R5 dummy enable", {31'd0, sread_en}, 32'd1);
      else if (k <= 17) chk(req, {30'd0, sread_en, sread}, {30'd0, 1'b1, exp[17-k]});
      else              chk("R5 release", {31'd0, sread_en}, 32'd0);
    end
    sle = 1'b0; wait_clk(8);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = '0;
    wait_clk(3);
    // R3 reset state
    check_all("R3 reset regs");
    chk("R3 reset en", {30'd0, sread_en, sread}, 32'd0);
    rst_n = 1'b1; wait_clk(4);

    // R1 R2 sweep, forward then reverse order
    for (int i = 0; i < 16; i++) write_reg(((32'h9E37_79B9 * (i + 1)) & 32'hFFFF_FFF0) | i);
    check_all("R1 R2 fwd sweep");
    for (int i = 15; i >= 0; i--) begin
      write_reg(((32'h7F4A_7C15 ^ (32'h0101_0101 << i)) & 32'hFFFF_FFF0) | i);
      check_all("R2 single slot");
    end
    write_reg(32'h8000_0005);
    chk("R1 msb first", regs[5*32 +: 32], 32'h8000_0005);

    // R6 R4 signal-level word over all gain codes
    for (int a = 0; a < 4; a++) for (int f = 0; f < 4; f++) begin
      lna = 2'(a); filt = 2'(f); level = 7'(a * 23 + f * 5 + 1);
      readback(3'd0, {5'd0, lna, filt, level}, "R6 level word");
    end
    // R4 other sources
    foreach (fofs[i]) begin end
    fofs = 16'h8000; readback(3'd1, 16'h8000, "R4 offset");
    fofs = 16'h7FFF; readback(3'd1, 16'h7FFF, "R4 offset");
    fofs = 16'hA53C; readback(3'd1, 16'hA53C, "R4 offset");
    meas = 7'h7F; readback(3'd2, 16'h007F, "R6 meas");
    meas = 7'h2A; readback(3'd2, 16'h002A, "R6 meas");
    rev = 16'hC3A1; readback(3'd3, 16'hC3A1, "R4 revision");
    cal = 8'hB6; readback(3'd4, 16'h00B6, "R6 cal");
    for (int m = 5; m < 8; m++) readback(3'(m), 16'h0000, "R4 unused mode");

    // R7 abort mid-readback
    rev = 16'hFFFF;
    shift_word({23'd0, 1'b1, 1'b0, 3'd3, 4'd7});
    sle = 1'b1; wait_clk(8);
    for (int k = 0; k < 5; k++) pulse();
    chk("R7 running", {31'd0, sread_en}, 32'd1);
    sle = 1'b0; wait_clk(8);
    chk("R7 abort", {30'd0, sread_en, sread}, 32'd0);
    pulse(); pulse();
    chk("R7 stays off", {31'd0, sread_en}, 32'd0);

    // R9 enable bit clear
    shift_word(32'h0000_0037);
    sle = 1'b1; wait_clk(8);
    shadow[7] = 32'h0000_0037;
    chk("R9 stored", regs[7*32 +: 32], 32'h0000_0037);
    pulse(); pulse();
    chk("R9 no drive", {31'd0, sread_en}, 32'd0);
    sle = 1'b0; wait_clk(8);

    // R8 chip-enable low: no shift, no latch
    ce = 1'b0; wait_clk(6);
    write_reg(32'hDEAD_BEE3);
    check_all("R8 ignore latch");
    ce = 1'b1; wait_clk(6);
    sle = 1'b1; wait_clk(8); sle = 1'b0; wait_clk(8);
    chk("R8 no shift", regs[7*32 +: 32], 32'h0000_0037);
    // R8 abort readback
    shift_word({23'd0, 1'b1, 1'b0, 3'd3, 4'd7});
    sle = 1'b1; wait_clk(8);
    pulse(); pulse();
    chk("R8 running", {31'd0, sread_en}, 32'd1);
    ce = 1'b0; wait_clk(8);
    chk("R8 abort", {31'd0, sread_en}, 32'd0);
    sle = 1'b0; wait_clk(4); ce = 1'b1; wait_clk(8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule